// File: doc/BRIEF.md
# Multiplexed ADC Scan Controller

This block is the control logic of a 16-channel analog acquisition front end that is reached over an 8-bit register bus. Software sets a scan window by naming a first and a last channel, stores a gain code per channel, and picks what starts a conversion: nothing, a bus write, a rising edge on an external pin, or a pacer tick. Each accepted trigger starts one conversion on an external 12-bit converter. The conversion uses the channel under the scan pointer and that channel's stored gain. The pointer then moves one step through the window and wraps back to its first channel.

When the converter reports completion, the block latches a 16-bit result word. The sample sits in the upper twelve bits and the channel number in the lower four, so software can spot a dropped channel. The block also raises a data-ready flag and then either an interrupt or a DMA request. A trigger that arrives while a conversion is still running is dropped and sets a sticky overrun flag. The input wiring strap selects single-ended mode (16 channels) or differential mode (8 channels). In differential mode the channel index wraps within the lower eight.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the scan window is channel 0 to channel 0, every gain code is 0, the control register reads 0, no conversion is busy, and irq_o, dma_req_o, overrun_o and conv_start_o are low.
- R2: A write to offset 2 sets the first channel from data bits[3:0] and the last channel from bits[7:4]. It also moves the scan pointer to the first channel and selects the channel whose gain the next gain write will store. Reading offset 2 returns {last, first}.
- R3: Each accepted trigger converts the channel under the pointer. The pointer then advances by one. When the pointer is equal to the last channel, it goes back to the first channel instead. Status bits[3:0] show the pointer.
- R4: A write to offset 1 stores data bits[3:0] as the gain code of the channel selected by the last write to offset 2. conv_gain_o presents the stored code of the channel being converted.
- R5: Offset 0 reads the low byte and offset 1 reads the high byte of the last result word. The word holds the channel in bits[3:0] and the 12-bit sample in bits[15:4].
- R6: With trigger mode 1 (software), any write to offset 0 is a trigger event. In other modes such writes do nothing.
- R7: Control bits[1:0] select the trigger: 0 disables every trigger, 2 takes rising edges of ext_trig_i, and 3 takes every cycle in which pacer_tick_i is high. Sources other than the selected one have no effect.
- R8: A trigger event while a conversion is busy, which includes the cycle in which its completion arrives, is dropped and sets overrun_o. overrun_o holds until a write to offset 8. When a drop and that write fall in the same cycle, the flag is set.
- R9: On completion, status bit 4 (ready) sets. irq_o is high while ready is set, control bit 7 is 1 and control bit 2 is 0. irq_sel_o shows control bits[6:4].
- R10: Any write to offset 8 clears ready, and irq_o with it. A completion in the same cycle wins, and ready stays set.
- R11: With control bit 2 set, a completion raises dma_req_o and irq_o stays low. dma_ack_i clears dma_req_o, unless a completion arrives in the same cycle.
- R12: Status bit 5 shows se_mode_i and bit 6 shows uni_mode_i. When se_mode_i is low, the issued channel and the pointer step use only the lower 8 channels, so the pointer wraps from 7 to 0.
- R13: conv_start_o is a one-cycle pulse in the cycle after an accepted trigger. conv_chan_o and conv_gain_o are valid with it and hold until the next start. Status bit 7 is high from the start until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| se_mode_i | input | 1 | Input wiring strap: 1 = single-ended, 0 = differential |
| uni_mode_i | input | 1 | Polarity strap: 1 = unipolar |
| ext_trig_i | input | 1 | External trigger, rising edge |
| pacer_tick_i | input | 1 | Pacer trigger, one event per high cycle |
| conv_start_o | output | 1 | Start pulse to the converter |
| conv_chan_o | output | 4 | Channel under conversion |
| conv_gain_o | output | 4 | Gain code under conversion |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_data_i | input | 12 | Converter sample, valid with conv_done_i |
| irq_o | output | 1 | Interrupt request |
| irq_sel_o | output | 3 | Interrupt line select |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge |
| overrun_o | output | 1 | Sticky dropped-trigger flag |

## Verification
Completion can fall in the same cycle as three other events: a new trigger, a status clear, or a DMA acknowledge. In each case the completion has to win. The trigger is dropped with overrun, while the ready flag and the DMA request stay set. The bench provokes these collisions with a behavioural converter and a sweep. It varies the converter latency against the pacer period while clear writes run at a fixed rhythm, and it holds the acknowledge high across a completion. It counts the collisions it reaches, and a cycle-accurate reference model judges every output in every cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  parameter int unsigned CHANS    = 16;
  parameter int unsigned CH_W     = $clog2(CHANS);
  parameter int unsigned SAMPLE_W = 12;
  parameter int unsigned GAIN_W   = 4;
  parameter int unsigned DATA_W   = 8;
  parameter int unsigned ADDR_W   = 4;
  parameter int unsigned RES_W    = SAMPLE_W + CH_W;

  localparam logic [ADDR_W-1:0] OFS_DATA = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_GAIN = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_MUX  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'd9;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_SOFT  = 2'd1,
    TRIG_EXT   = 2'd2,
    TRIG_PACER = 2'd3
  } trig_e;

  typedef struct packed {
    logic       inte;
    logic [2:0] irq_sel;
    logic       spare;
    logic       dmae;
    trig_e      trig;
  } ctrl_t;
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CH_W-1:0]   rd_chan_i,
  output logic [CH_W-1:0]   first_o,
  output logic [CH_W-1:0]   last_o,
  output ctrl_t             ctrl_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              win_load_o,
  output logic              soft_wr_o,
  output logic              clr_o
);
  logic              gain_we, ctrl_we;
  logic [CH_W-1:0]   sel_q, first_q, last_q;
  ctrl_t             ctrl_q;
  logic [GAIN_W-1:0] gain_q [CHANS];

  assign win_load_o = wr_i && (addr_i == OFS_MUX);
  assign gain_we    = wr_i && (addr_i == OFS_GAIN);
  assign ctrl_we    = wr_i && (addr_i == OFS_CTRL);
  assign soft_wr_o  = wr_i && (addr_i == OFS_DATA);
  assign clr_o      = wr_i && (addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
      sel_q   <= '0;
    end else if (win_load_o) begin
      first_q <= wdata_i[CH_W-1:0];
      last_q  <= wdata_i[2*CH_W-1:CH_W];
      sel_q   <= wdata_i[CH_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wdata_i);
  end

  for (genvar g = 0; g < CHANS; g++) begin : g_gain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             gain_q[g] <= '0;
      else if (gain_we && sel_q == CH_W'(g))   gain_q[g] <= wdata_i[GAIN_W-1:0];
    end
  end

  assign gain_o  = gain_q[rd_chan_i];
  assign first_o = first_q;
  assign last_o  = last_q;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  trig_e             mode_i,
  input  logic              soft_wr_i,
  input  logic              ext_trig_i,
  input  logic              pacer_tick_i,
  input  logic              se_mode_i,
  input  logic [CH_W-1:0]   first_i,
  input  logic [CH_W-1:0]   last_i,
  input  logic              win_load_i,
  input  logic [CH_W-1:0]   load_first_i,
  input  logic              conv_done_i,
  input  logic              ovr_clr_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [CH_W-1:0]   issue_chan_o,
  output logic [CH_W-1:0]   ptr_o,
  output logic              start_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overrun_o
);
  localparam int unsigned HALF = CHANS / 2;
  localparam logic [CH_W-1:0] MASK_SE   = CH_W'(CHANS - 1);
  localparam logic [CH_W-1:0] MASK_DIFF = CH_W'(HALF - 1);

  logic            ext_q, busy_q, start_q, ovr_q, trig_ev, accept;
  logic [CH_W-1:0] ptr_q, chan_q, mask, ptr_step;
  logic [GAIN_W-1:0] gain_q;

  always_comb begin
    unique case (mode_i)
      TRIG_SOFT:  trig_ev = soft_wr_i;
      TRIG_EXT:   trig_ev = ext_trig_i && !ext_q;
      TRIG_PACER: trig_ev = pacer_tick_i;
      default:    trig_ev = 1'b0;
    endcase
  end

  assign mask         = se_mode_i ? MASK_SE : MASK_DIFF;
  assign issue_chan_o = ptr_q & mask;
  assign ptr_step     = (ptr_q == last_i) ? first_i : ((ptr_q + 1'b1) & mask);
  assign accept       = trig_ev && !busy_q;
  assign done_o       = conv_done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_trig_i;
  end

  // window write overrides a same-cycle advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (win_load_i) ptr_q <= load_first_i;
    else if (accept)     ptr_q <= ptr_step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
      gain_q  <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        chan_q <= issue_chan_o;
        gain_q <= gain_i;
      end else if (done_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovr_q <= 1'b0;
    else if (trig_ev && busy_q)  ovr_q <= 1'b1;
    else if (ovr_clr_i)          ovr_q <= 1'b0;
  end

  assign ptr_o     = ptr_q;
  assign start_o   = start_q;
  assign chan_o    = chan_q;
  assign gain_o    = gain_q;
  assign busy_o    = busy_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/adc_scan_result.sv
module adc_scan_result
  import adc_scan_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                clr_i,
  input  logic                dmae_i,
  input  logic                inte_i,
  input  logic                dma_ack_i,
  output logic [RES_W-1:0]    result_o,
  output logic                ready_o,
  output logic                irq_o,
  output logic                dma_req_o
);
  logic [RES_W-1:0] res_q;
  logic             ready_q, dma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (done_i) res_q <= {data_i, chan_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ready_q <= 1'b0;
    else if (done_i) ready_q <= 1'b1;
    else if (clr_i)  ready_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               dma_q <= 1'b0;
    else if (done_i && dmae_i) dma_q <= 1'b1;
    else if (dma_ack_i)        dma_q <= 1'b0;
  end

  assign result_o  = res_q;
  assign ready_o   = ready_q;
  assign irq_o     = ready_q && inte_i && !dmae_i;
  assign dma_req_o = dma_q;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                se_mode_i,
  input  logic                uni_mode_i,
  input  logic                ext_trig_i,
  input  logic                pacer_tick_i,
  output logic                conv_start_o,
  output logic [CH_W-1:0]     conv_chan_o,
  output logic [GAIN_W-1:0]   conv_gain_o,
  input  logic                conv_done_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                irq_o,
  output logic [2:0]          irq_sel_o,
  output logic                dma_req_o,
  input  logic                dma_ack_i,
  output logic                overrun_o
);
  logic [CH_W-1:0]   first, last, issue_chan, ptr;
  logic [GAIN_W-1:0] lut_gain;
  logic              win_load, soft_wr, clr, busy, done, ready;
  logic [1:0]        trig_mode;
  logic [RES_W-1:0]  result;
  ctrl_t             ctrl;

  adc_scan_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rd_chan_i  (issue_chan),
    .first_o    (first),
    .last_o     (last),
    .ctrl_o     (ctrl),
    .gain_o     (lut_gain),
    .win_load_o (win_load),
    .soft_wr_o  (soft_wr),
    .clr_o      (clr)
  );

  adc_scan_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (ctrl.trig),
    .soft_wr_i    (soft_wr),
    .ext_trig_i   (ext_trig_i),
    .pacer_tick_i (pacer_tick_i),
    .se_mode_i    (se_mode_i),
    .first_i      (first),
    .last_i       (last),
    .win_load_i   (win_load),
    .load_first_i (bus_wdata_i[CH_W-1:0]),
    .conv_done_i  (conv_done_i),
    .ovr_clr_i    (clr),
    .gain_i       (lut_gain),
    .issue_chan_o (issue_chan),
    .ptr_o        (ptr),
    .start_o      (conv_start_o),
    .chan_o       (conv_chan_o),
    .gain_o       (conv_gain_o),
    .busy_o       (busy),
    .done_o       (done),
    .overrun_o    (overrun_o)
  );

  adc_scan_result i_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .data_i    (conv_data_i),
    .chan_i    (conv_chan_o),
    .clr_i     (clr),
    .dmae_i    (ctrl.dmae),
    .inte_i    (ctrl.inte),
    .dma_ack_i (dma_ack_i),
    .result_o  (result),
    .ready_o   (ready),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
  );

  assign trig_mode = ctrl.trig;
  assign irq_sel_o = ctrl.irq_sel;

  always_comb begin
    unique case (bus_addr_i)
      OFS_DATA: bus_rdata_o = result[DATA_W-1:0];
      OFS_GAIN: bus_rdata_o = result[RES_W-1:DATA_W];
      OFS_MUX:  bus_rdata_o = {last, first};
      OFS_STAT: bus_rdata_o = {busy, uni_mode_i, se_mode_i, ready, ptr};
      OFS_CTRL: bus_rdata_o = ctrl;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk
  import adc_scan_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              conv_start_o,
  input logic              conv_done_i,
  input logic              overrun_o,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic              dma_ack_i,
  input logic [1:0]        trig_mode,
  input logic              busy
);
  a_r13_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  a_r13_busy_with_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy);

  a_r8_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !conv_start_o);

  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !(bus_wr_i && bus_addr_i == OFS_STAT) |=> overrun_o);

  a_r7_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_mode == 2'd0 |=> !conv_start_o);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == OFS_STAT && !conv_done_i |=> !irq_o);

  a_r11_dma_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !dma_ack_i |=> dma_req_o);

  a_r11_dma_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_ack_i && !conv_done_i |=> !dma_req_o);
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_wr_i     (bus_wr_i),
  .bus_addr_i   (bus_addr_i),
  .conv_start_o (conv_start_o),
  .conv_done_i  (conv_done_i),
  .overrun_o    (overrun_o),
  .irq_o        (irq_o),
  .dma_req_o    (dma_req_o),
  .dma_ack_i    (dma_ack_i),
  .trig_mode    (trig_mode),
  .busy         (busy)
);

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bus_wr_i = 0, se_mode_i = 1, uni_mode_i = 0, ext_trig_i = 0, pacer_tick_i = 0;
  logic [3:0] bus_addr_i = 0;
  logic [7:0] bus_wdata_i = 0, bus_rdata_o;
  logic conv_start_o, conv_done_i = 0, irq_o, dma_req_o, dma_ack_i = 0, overrun_o;
  logic [3:0] conv_chan_o, conv_gain_o;
  logic [11:0] conv_data_i = 0;
  logic [2:0] irq_sel_o;

  always #2.5 clk_i = ~clk_i;

  adc_scan_ctrl i_adc_scan_ctrl (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, start_cnt = 0, co_trig = 0, co_clr = 0, co_ack = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural converter stub
  int stub_lat = 2, stub_cnt = 0, stub_seq = 0, stub_chan = 0, last_data = 0;
  always @(negedge clk_i) begin
    conv_done_i = 0;
    if (conv_start_o) begin
      stub_cnt = stub_lat; stub_chan = int'(conv_chan_o);
    end else if (stub_cnt > 0) begin
      stub_cnt--;
      if (stub_cnt == 0) begin
        stub_seq++;
        last_data = (stub_seq * 113 + stub_chan * 7 + 5) & 12'hFFF;
        conv_data_i = 12'(last_data);
        conv_done_i = 1;
      end
    end
  end

  // reference model
  int m_first, m_last, m_ptr, m_sel, m_ctrl, m_busy, m_ready, m_ovr, m_dma, m_res;
  int m_start, m_chan, m_gout, m_ext;
  int m_gain[16];
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_first = 0; m_last = 0; m_ptr = 0; m_sel = 0; m_ctrl = 0; m_busy = 0;
      m_ready = 0; m_ovr = 0; m_dma = 0; m_res = 0; m_start = 0; m_chan = 0;
      m_gout = 0; m_ext = 0;
      foreach (m_gain[i]) m_gain[i] = 0;
    end else begin
      int mode, mask, ev, done, old_busy, rset, oset, dset, a, d;
      mode = m_ctrl & 3; mask = se_mode_i ? 15 : 7;
      a = int'(bus_addr_i); d = int'(bus_wdata_i);
      ev = (mode == 1 && bus_wr_i && a == 0) || (mode == 2 && ext_trig_i && !m_ext) ||
           (mode == 3 && pacer_tick_i);
      m_ext = ext_trig_i;
      old_busy = m_busy; rset = 0; oset = 0; dset = 0; m_start = 0;
      done = conv_done_i && old_busy;
      if (done) begin
        m_res = (int'(conv_data_i) << 4) | m_chan; m_busy = 0; rset = 1;
        if (m_ctrl & 4) dset = 1;
      end
      if (ev) begin
        if (!old_busy) begin
          m_start = 1; m_chan = m_ptr & mask; m_gout = m_gain[m_chan]; m_busy = 1;
          m_ptr = (m_ptr == m_last) ? m_first : ((m_ptr + 1) & mask);
        end else oset = 1;
      end
      if (bus_wr_i) begin
        if (a == 2) begin m_first = d & 15; m_last = d >> 4; m_ptr = m_first; m_sel = d & 15; end
        if (a == 1) m_gain[m_sel] = d & 15;
        if (a == 9) m_ctrl = d;
      end
      if (rset) m_ready = 1; else if (bus_wr_i && a == 8) m_ready = 0;
      if (oset) m_ovr = 1;   else if (bus_wr_i && a == 8) m_ovr = 0;
      if (dset) m_dma = 1;   else if (dma_ack_i) m_dma = 0;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_res & 255;
      1: return (m_res >> 8) & 255;
      2: return (m_last << 4) | m_first;
      8: return m_ptr | (m_ready << 4) | (int'(se_mode_i) << 5) | (int'(uni_mode_i) << 6) | (m_busy << 7);
      9: return m_ctrl;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison, away from the edge
  always @(posedge clk_i) begin
    if (conv_done_i && pacer_tick_i) co_trig++;
    if (conv_done_i && bus_wr_i && bus_addr_i == 4'd8) co_clr++;
    if (conv_done_i && dma_ack_i) co_ack++;
    #1;
    if (rst_ni) begin
      if (conv_start_o) start_cnt++;
      chk("R13 conv_start_o", int'(conv_start_o), m_start);
      chk("R3 conv_chan_o", int'(conv_chan_o), m_chan);
      chk("R4 conv_gain_o", int'(conv_gain_o), m_gout);
      chk("R9 irq_o", int'(irq_o), (m_ready && (m_ctrl & 128) && !(m_ctrl & 4)) ? 1 : 0);
      chk("R9 irq_sel_o", int'(irq_sel_o), (m_ctrl >> 4) & 7);
      chk("R11 dma_req_o", int'(dma_req_o), m_dma);
      chk("R8 overrun_o", int'(overrun_o), m_ovr);
      chk("R5 bus_rdata_o", int'(bus_rdata_o), exp_rd(int'(bus_addr_i)));
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    bus_wr_i = 1; bus_addr_i = 4'(a); bus_wdata_i = 8'(d);
    @(negedge clk_i);
    bus_wr_i = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk_i);
    bus_addr_i = 4'(a);
    @(posedge clk_i); #1;
    v = int'(bus_rdata_o);
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 200 && !irq_o; k++) @(negedge clk_i);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && (m_busy != 0); k++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    int v, lo, hi, n0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    // R1 reset state
    rd(8, v); chk("R1 status after reset", v, 32);
    rd(9, v); chk("R1 ctrl after reset", v, 0);
    rd(2, v); chk("R1 window after reset", v, 0);
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 dma_req_o", int'(dma_req_o), 0);
    chk("R1 overrun_o", int'(overrun_o), 0);

    // R4 per-channel gains
    for (int ch = 3; ch <= 5; ch++) begin wr(2, ch); wr(1, ch + 8); end
    wr(2, 8'h53);
    rd(2, v); chk("R2 window readback", v, 8'h53);
    rd(8, v); chk("R2 pointer at first", v & 15, 3);
    wr(9, 8'hB1);
    for (int i = 0; i < 5; i++) begin
      int ec;
      ec = 3 + (i % 3);
      wr(0, 0);
      chk("R6 soft start", int'(conv_start_o), 1);
      chk("R3 scan channel", int'(conv_chan_o), ec);
      chk("R4 stored gain", int'(conv_gain_o), ec + 8);
      @(negedge clk_i);
      chk("R13 start one cycle", int'(conv_start_o), 0);
      wait_irq();
      rd(0, lo); rd(1, hi);
      chk("R5 channel tag", lo & 15, ec);
      chk("R5 sample field", (hi << 4) | (lo >> 4), last_data);
      chk("R9 irq line", int'(irq_sel_o), 3);
      wr(8, 0);
      chk("R10 clear drops irq", int'(irq_o), 0);
    end

    // R8 overrun
    stub_lat = 8;
    wr(0, 0); wr(0, 0);
    chk("R8 overrun set", int'(overrun_o), 1);
    wait_irq(); wr(8, 0);
    chk("R8 overrun cleared", int'(overrun_o), 0);
    stub_lat = 2;

    // R7 disabled mode ignores everything
    wr(9, 8'h80);
    n0 = start_cnt;
    wr(0, 0);
    @(negedge clk_i) begin ext_trig_i = 1; pacer_tick_i = 1; end
    repeat (3) @(negedge clk_i);
    ext_trig_i = 0; pacer_tick_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R7 mode 0 ignores triggers", start_cnt, n0);

    // R7 ext mode: one edge, pacer and soft ignored
    wr(9, 8'h82);
    n0 = start_cnt;
    @(negedge clk_i) begin ext_trig_i = 1; pacer_tick_i = 1; end
    repeat (4) @(negedge clk_i);
    ext_trig_i = 0; pacer_tick_i = 0;
    wait_idle();
    wr(0, 0); wait_idle();
    chk("R7 ext edge only", start_cnt, n0 + 1);
    wr(8, 0);

    // coincidence sweep in pacer mode
    wr(9, 8'h83);
    for (int lat = 1; lat <= 4; lat++)
      for (int per = 2; per <= 6; per++) begin
        stub_lat = lat;
        for (int c = 0; c < 30; c++) begin
          @(negedge clk_i);
          pacer_tick_i = (c % per == 0);
          bus_wr_i = (c % 3 == 1); bus_addr_i = 4'd8; bus_wdata_i = 0;
        end
        @(negedge clk_i) begin pacer_tick_i = 0; bus_wr_i = 0; end
        wait_idle();
      end
    chk("R8 trigger met completion", (co_trig > 0) ? 1 : 0, 1);
    chk("R10 clear met completion", (co_clr > 0) ? 1 : 0, 1);
    wr(8, 0);

    // R11 DMA path
    stub_lat = 3;
    wr(9, 8'h85);
    wr(0, 0);
    for (int k = 0; k < 50 && !dma_req_o; k++) @(negedge clk_i);
    chk("R11 dma raised", int'(dma_req_o), 1);
    chk("R11 irq held low", int'(irq_o), 0);
    @(negedge clk_i) dma_ack_i = 1;
    @(negedge clk_i) dma_ack_i = 0;
    chk("R11 ack clears", int'(dma_req_o), 0);
    dma_ack_i = 1;
    wr(0, 0);
    repeat (8) @(negedge clk_i);
    dma_ack_i = 0;
    @(negedge clk_i);
    chk("R11 ack met completion", (co_ack > 0) ? 1 : 0, 1);
    chk("R11 cleared after ack", int'(dma_req_o), 0);
    wr(8, 0);

    // R12 differential mode wrap
    se_mode_i = 0;
    wr(9, 8'h01);
    wr(2, 8'h16);
    for (int i = 0; i < 5; i++) begin
      int ec;
      ec = (i % 4 == 0) ? 6 : (i % 4 == 1) ? 7 : (i % 4 == 2) ? 0 : 1;
      wr(0, 0);
      chk("R12 diff channel", int'(conv_chan_o), ec);
      wait_idle();
    end
    rd(8, v); chk("R12 status diff", (v >> 5) & 1, 0);
    uni_mode_i = 1;
    rd(8, v); chk("R12 status unipolar", (v >> 6) & 1, 1);

    repeat (4) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule